// File: doc/BRIEF.md
# Event Timer with One Compare Channel

This block is a timer peripheral. It holds one 64-bit main counter and one compare channel, and software reaches all of its state through a 32-bit register port with separate read and write strobes. A global run bit starts and stops the counter. The counter can be loaded one 32-bit half at a time. The channel compares the counter against a target. On a match it sets a status flag and, if its interrupt enable is set, it drives the interrupt line.

The channel runs in one of two modes. In one-shot mode the comparator holds an absolute target, and the channel fires once for each target written. In periodic mode the comparator moves forward by a programmed period on every match. A self-clearing load flag lets software set the first target and the period through two successive writes to the same comparator offset. The status flag is cleared by writing 1 to it. A channel option restricts both counting and comparison to the low 32 bits.

Register map (byte offsets): 0x00 global config, 0x04 status, 0x08 counter low, 0x0C counter high, 0x10 channel config, 0x14 comparator low, 0x18 comparator high. Read data appears on the cycle after the read strobe, and it is zero on cycles with no read.

Top module: `evt_timer`

## Requirements
- R1: After reset, every register reads 0, the counter is stopped and `irq_o` is low.
- R2: While global config bit 0 is 1, the counter rises by 1 on each clock. While it is 0, the counter holds its value.
- R3: Writes to 0x08 and 0x0C replace the low and high counter halves. The other half is kept, and either half reads back at the same offset.
- R4: `rdata` carries the addressed register one cycle after `rd_en`. It is zero for offsets that are not mapped (such as 0x1C, or any offset not a multiple of 4) and on cycles with no read.
- R5: In one-shot mode (channel config bit 2 = 0), a comparator write loads the target and arms the channel. The first match sets the status bit and disarms the channel, so a later pass of the counter over the same target raises nothing.
- R6: With periodic mode (bit 2) and the load flag (bit 3) both set, the first write to 0x14 sets the compare value, and the second write to 0x14 sets the period. Writes to 0x18 go to the same target as the pending low write. The second write clears bit 3, which reads back as 0.
- R7: In periodic mode, each match adds the period to the comparator in the same cycle. Reading 0x14 and 0x18 returns the current compare value.
- R8: In periodic mode with the load flag clear, a comparator write changes only the period.
- R9: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged, and a match in the same cycle wins over the clear.
- R10: With bit 0 = 1 (level type), `irq_o` is the status bit ANDed with the interrupt enable (bit 1). With bit 0 = 0 (edge type), `irq_o` is a one-cycle pulse for each match.
- R11: With the interrupt enable clear, `irq_o` stays low, while the counter keeps running and the status bit still sets on matches.
- R12: With bit 4 (32-bit mode) set, the low counter half wraps from 0xFFFFFFFF to 0 and leaves the high half unchanged. The match compares only the low 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt output |

## Verification
The hardest case to reach is the 32-bit mode wrap. Reaching it by counting would take 2^32 cycles, so the stimulus first loads the low counter half with a value just below the wrap point. It then sets a target whose high half differs from the counter's, so a match can only occur if the high bits are really ignored. The one-shot disarm case is reached by stopping the counter, rewinding it below the old target and running it across that target again. The load-flag sequence is driven by interleaving high and low comparator writes, so that the routing of the first target and the period is checked word by word.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam logic [7:0] OFS_GCFG   = 8'h00;
  localparam logic [7:0] OFS_STAT   = 8'h04;
  localparam logic [7:0] OFS_CNT_LO = 8'h08;
  localparam logic [7:0] OFS_CNT_HI = 8'h0C;
  localparam logic [7:0] OFS_CHCFG  = 8'h10;
  localparam logic [7:0] OFS_CMP_LO = 8'h14;
  localparam logic [7:0] OFS_CMP_HI = 8'h18;

  // channel configuration, LSB first: level, ie, periodic, load flag, 32-bit
  typedef struct packed {
    logic f32;
    logic load;
    logic per;
    logic ie;
    logic level;
  } ch_cfg_t;

  localparam int CH_CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          f32,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [2*DW-1:0] count
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] nxt_inc;

  always_comb begin
    if (f32) nxt_inc = {count[CW-1:DW], count[DW-1:0] + DW'(1)};
    else     nxt_inc = count + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (wr_lo) begin
      count[DW-1:0] <= wdata;
    end else if (wr_hi) begin
      count[CW-1:DW] <= wdata;
    end else if (run) begin
      count <= nxt_inc;
    end
  end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [2*DW-1:0] count,
  input  logic            wr_cfg,
  input  logic            wr_cmp_lo,
  input  logic            wr_cmp_hi,
  input  logic            wr_stat,
  input  logic [DW-1:0]   wdata,
  output ch_cfg_t         cfg,
  output logic [2*DW-1:0] cmp,
  output logic            status,
  output logic            hit,
  output logic            irq_o
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] period;
  logic [CW-1:0] cmp_adv;
  logic          armed;
  logic          phase;
  logic          eq;
  logic          to_cmp;
  logic          clr_req;
  logic          stat_nxt;

  always_comb begin
    if (cfg.f32) eq = (count[DW-1:0] == cmp[DW-1:0]);
    else         eq = (count == cmp);
    hit = run & (cfg.per | armed) & eq;
    if (cfg.f32) cmp_adv = {cmp[CW-1:DW], cmp[DW-1:0] + period[DW-1:0]};
    else         cmp_adv = cmp + period;
    to_cmp   = ~cfg.per | (cfg.load & ~phase);
    clr_req  = wr_stat & wdata[0];
    stat_nxt = hit | (status & ~clr_req);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      cmp    <= '0;
      period <= '0;
      armed  <= 1'b0;
      phase  <= 1'b0;
      status <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      status <= stat_nxt;
      irq_o  <= cfg.ie & (cfg.level ? stat_nxt : hit);
      if (hit && cfg.per)  cmp   <= cmp_adv;
      if (hit && !cfg.per) armed <= 1'b0;
      if (wr_cfg) begin
        cfg   <= ch_cfg_t'(wdata[CH_CFG_W-1:0]);
        phase <= 1'b0;
      end
      if (wr_cmp_lo || wr_cmp_hi) armed <= 1'b1;
      if (wr_cmp_lo) begin
        if (to_cmp) cmp[DW-1:0]    <= wdata;
        else        period[DW-1:0] <= wdata;
        if (cfg.per && cfg.load) begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase    <= 1'b0;
            cfg.load <= 1'b0;
          end
        end
      end
      if (wr_cmp_hi) begin
        if (to_cmp) cmp[CW-1:DW]    <= wdata;
        else        period[CW-1:DW] <= wdata;
      end
    end
  end
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit0,
  input  ch_cfg_t           cfg,
  input  logic              status,
  input  logic [2*DW-1:0]   count,
  input  logic [2*DW-1:0]   cmp,
  output logic              run,
  output logic              wr_stat,
  output logic              wr_cnt_lo,
  output logic              wr_cnt_hi,
  output logic              wr_cfg,
  output logic              wr_cmp_lo,
  output logic              wr_cmp_hi,
  output logic [DW-1:0]     rdata
);
  localparam int CW = 2 * DW;

  logic [DW-1:0] rd_mux;

  always_comb begin
    wr_stat   = wr_en && (addr == OFS_STAT[ADDR_W-1:0]);
    wr_cnt_lo = wr_en && (addr == OFS_CNT_LO[ADDR_W-1:0]);
    wr_cnt_hi = wr_en && (addr == OFS_CNT_HI[ADDR_W-1:0]);
    wr_cfg    = wr_en && (addr == OFS_CHCFG[ADDR_W-1:0]);
    wr_cmp_lo = wr_en && (addr == OFS_CMP_LO[ADDR_W-1:0]);
    wr_cmp_hi = wr_en && (addr == OFS_CMP_HI[ADDR_W-1:0]);
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_GCFG[ADDR_W-1:0]:   rd_mux = DW'(run);
      OFS_STAT[ADDR_W-1:0]:   rd_mux = DW'(status);
      OFS_CNT_LO[ADDR_W-1:0]: rd_mux = count[DW-1:0];
      OFS_CNT_HI[ADDR_W-1:0]: rd_mux = count[CW-1:DW];
      OFS_CHCFG[ADDR_W-1:0]:  rd_mux = DW'(cfg);
      OFS_CMP_LO[ADDR_W-1:0]: rd_mux = cmp[DW-1:0];
      OFS_CMP_HI[ADDR_W-1:0]: rd_mux = cmp[CW-1:DW];
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr_en && (addr == OFS_GCFG[ADDR_W-1:0])) run <= wbit0;
      rdata <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq_o
);
  localparam int CW = 2 * DW;

  logic          run;
  logic          wr_stat, wr_cnt_lo, wr_cnt_hi, wr_cfg, wr_cmp_lo, wr_cmp_hi;
  logic [CW-1:0] count;
  logic [CW-1:0] cmp;
  ch_cfg_t       ch_cfg;
  logic          status;
  logic          hit;

  evt_timer_regs #(.DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wbit0(wdata[0]), .cfg(ch_cfg), .status(status), .count(count), .cmp(cmp),
    .run(run), .wr_stat(wr_stat), .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi),
    .wr_cfg(wr_cfg), .wr_cmp_lo(wr_cmp_lo), .wr_cmp_hi(wr_cmp_hi), .rdata(rdata)
  );

  evt_main_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .f32(ch_cfg.f32),
    .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi), .wdata(wdata), .count(count)
  );

  evt_channel #(.DW(DW)) u_ch (
    .clk(clk), .rst(rst), .run(run), .count(count),
    .wr_cfg(wr_cfg), .wr_cmp_lo(wr_cmp_lo), .wr_cmp_hi(wr_cmp_hi),
    .wr_stat(wr_stat), .wdata(wdata), .cfg(ch_cfg), .cmp(cmp),
    .status(status), .hit(hit), .irq_o(irq_o)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     rdata,
  input logic              irq_o,
  input logic              run,
  input logic [2*DW-1:0]   count,
  input ch_cfg_t           ch_cfg,
  input logic              status,
  input logic              hit
);
  logic wr_cnt, wr_st, unmapped;
  assign wr_cnt   = wr_en && (addr == OFS_CNT_LO[ADDR_W-1:0] || addr == OFS_CNT_HI[ADDR_W-1:0]);
  assign wr_st    = wr_en && (addr == OFS_STAT[ADDR_W-1:0]);
  assign unmapped = (addr[1:0] != 2'b00) || (addr > OFS_CMP_HI[ADDR_W-1:0]);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_cnt) |=> $stable(count));
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !wr_cnt && !ch_cfg.f32) |=> (count == $past(count) + 1'b1));
  assert_unmap_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && unmapped) |=> (rdata == '0));
  assert_match_sets_R5: assert property (@(posedge clk) disable iff (rst)
    hit |=> status);
  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_st && wdata[0] && !hit) |=> !status);
  assert_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_st && !wdata[0] && status) |=> status);
  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ch_cfg.ie));
endmodule

bind evt_timer evt_timer_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .run(run), .count(count),
  .ch_cfg(ch_cfg), .status(status), .hit(hit)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  bit    live   = 1'b0;
  string tag    = "R1";

  always #2.5 clk = ~clk;

  evt_timer u_evt_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  // behavioural reference model
  bit [63:0] m_cnt, m_cmp, m_per;
  bit        m_run, m_lvl, m_ie, m_pm, m_ld, m_f32, m_ph, m_arm, m_st, m_irq;
  bit [31:0] m_rd;

  always @(posedge clk) begin
    bit hit, eq, st_n, tocmp;
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_per = 0; m_run = 0; m_lvl = 0; m_ie = 0; m_pm = 0;
      m_ld = 0; m_f32 = 0; m_ph = 0; m_arm = 0; m_st = 0; m_irq = 0; m_rd = 0;
    end else begin
      eq  = m_f32 ? (m_cnt[31:0] == m_cmp[31:0]) : (m_cnt == m_cmp);
      hit = m_run && (m_pm || m_arm) && eq;
      m_rd = 0;
      if (rd_en) begin
        case (addr)
          5'h00: m_rd = {31'd0, m_run};
          5'h04: m_rd = {31'd0, m_st};
          5'h08: m_rd = m_cnt[31:0];
          5'h0C: m_rd = m_cnt[63:32];
          5'h10: m_rd = {27'd0, m_f32, m_ld, m_pm, m_ie, m_lvl};
          5'h14: m_rd = m_cmp[31:0];
          5'h18: m_rd = m_cmp[63:32];
          default: m_rd = 0;
        endcase
      end
      st_n  = hit || (m_st && !(wr_en && addr == 5'h04 && wdata[0]));
      m_irq = m_ie && (m_lvl ? st_n : hit);
      m_st  = st_n;
      if (wr_en && addr == 5'h08)      m_cnt[31:0]  = wdata;
      else if (wr_en && addr == 5'h0C) m_cnt[63:32] = wdata;
      else if (m_run) begin
        if (m_f32) m_cnt[31:0] = m_cnt[31:0] + 1;
        else       m_cnt = m_cnt + 1;
      end
      if (hit && m_pm) begin
        if (m_f32) m_cmp[31:0] = m_cmp[31:0] + m_per[31:0];
        else       m_cmp = m_cmp + m_per;
      end
      if (hit && !m_pm) m_arm = 0;
      tocmp = !m_pm || (m_ld && !m_ph);
      if (wr_en && (addr == 5'h14 || addr == 5'h18)) begin
        m_arm = 1;
        if (addr == 5'h14) begin
          if (tocmp) m_cmp[31:0] = wdata; else m_per[31:0] = wdata;
          if (m_pm && m_ld) begin
            if (!m_ph) m_ph = 1;
            else begin m_ph = 0; m_ld = 0; end
          end
        end else begin
          if (tocmp) m_cmp[63:32] = wdata; else m_per[63:32] = wdata;
        end
      end
      if (wr_en && addr == 5'h10) begin
        {m_f32, m_ld, m_pm, m_ie, m_lvl} = wdata[4:0];
        m_ph = 0;
      end
      if (wr_en && addr == 5'h00) m_run = wdata[0];
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      checks++;
      if (rdata !== m_rd) begin
        errors++;
        $display("FAIL %s rdata: actual=%h expected=%h", tag, rdata, m_rd);
      end
      checks++;
      if (irq_o !== m_irq) begin
        errors++;
        $display("FAIL %s irq_o: actual=%b expected=%b", tag, irq_o, m_irq);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h: actual=%h expected=%h", t, a, rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    live = 1'b1;
    // R1: reset state
    tag = "R1";
    for (int i = 0; i < 7; i++) rd_chk(5'(i * 4), 32'h0, "R1");
    checks++;
    if (irq_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 irq_o: actual=%b expected=0", irq_o);
    end
    // R3: counter halves
    tag = "R3";
    wr(5'h08, 32'h0000_0010);
    wr(5'h0C, 32'h0000_0002);
    rd_chk(5'h08, 32'h0000_0010, "R3");
    rd_chk(5'h0C, 32'h0000_0002, "R3");
    // R2: run and freeze
    tag = "R2";
    wr(5'h00, 32'h1);
    idle(20);
    wr(5'h00, 32'h0);
    idle(5);
    rd_chk(5'h08, 32'h0000_0010 + 32'd21, "R2");
    // R12 + R5: 32-bit mode wrap and low-half compare, one-shot
    tag = "R12";
    wr(5'h10, 32'h13);
    wr(5'h18, 32'h77);
    wr(5'h14, 32'h5);
    wr(5'h08, 32'hFFFF_FFF0);
    wr(5'h00, 32'h1);
    idle(40);
    wr(5'h00, 32'h0);
    rd_chk(5'h0C, 32'h0000_0002, "R12");
    tag = "R5";
    rd_chk(5'h04, 32'h1, "R5");
    // R9: write-1-to-clear
    tag = "R9";
    wr(5'h04, 32'h0);
    rd_chk(5'h04, 32'h1, "R9");
    wr(5'h04, 32'h1);
    rd_chk(5'h04, 32'h0, "R9");
    // R5: disarmed after firing
    tag = "R5";
    wr(5'h08, 32'h0);
    wr(5'h00, 32'h1);
    idle(20);
    wr(5'h00, 32'h0);
    rd_chk(5'h04, 32'h0, "R5");
    // R6: load-flag sequence, edge type
    tag = "R6";
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h0);
    wr(5'h10, 32'h0E);
    wr(5'h18, 32'h0);
    wr(5'h14, 32'd10);
    rd_chk(5'h10, 32'h0E, "R6");
    wr(5'h18, 32'h0);
    wr(5'h14, 32'd7);
    rd_chk(5'h10, 32'h06, "R6");
    rd_chk(5'h14, 32'd10, "R6");
    // R7 / R10: periodic advance and edge pulses
    tag = "R7";
    wr(5'h00, 32'h1);
    idle(40);
    wr(5'h00, 32'h0);
    rd_chk(5'h14, 32'd45, "R7");
    // R8: write with flag clear hits the period only
    tag = "R8";
    wr(5'h14, 32'd3);
    rd_chk(5'h14, 32'd45, "R8");
    wr(5'h00, 32'h1);
    idle(20);
    // R10: level type
    tag = "R10";
    wr(5'h10, 32'h07);
    idle(10);
    wr(5'h04, 32'h1);
    idle(4);
    // R11: enable clear keeps counting and status
    tag = "R11";
    wr(5'h10, 32'h04);
    wr(5'h04, 32'h1);
    idle(12);
    rd_chk(5'h04, 32'h1, "R11");
    wr(5'h00, 32'h0);
    // R4: unmapped offsets
    tag = "R4";
    rd_chk(5'h1C, 32'h0, "R4");
    rd_chk(5'h02, 32'h0, "R4");
    idle(2);
    live = 1'b0;
    finish_run();
  end
endmodule